// File: doc/BRIEF.md
# Edge-Triggered Event Pending Controller

This block watches a set of asynchronous event lines and turns selected edges on them into interrupt, event and wake-up requests. For each line software chooses whether a rising edge, a falling edge, or both trigger it, and whether the line reaches the interrupt path, the event path, or both. A line whose interrupt mask is open latches its trigger in a rising or a falling pending flag. That flag holds the line's interrupt until software clears it by writing a 1. A line whose event mask is open produces a one-cycle event pulse and needs no acknowledge.

Each input passes through a two-flop synchronizer and then an edge detector, all in the register clock domain. Software can also force a rising-edge trigger on any line. All the control state is read and written through a flat word-per-register port whose data width equals the line count.

Top module: `edge_event_ctrl`

## Requirements
- R1: After reset every register reads 0 and `line_irq`, `cpu_event`, `cpu_wake` and `sys_wake` are 0. Register indices on `reg_addr` are: 0 rising select, 1 falling select, 2 software trigger, 3 rising pending, 4 falling pending, 5 interrupt mask, 6 event mask. Indices 7 and up read 0. Bit i of each register belongs to line i.
- R2: A line with rising select set triggers on a 0-to-1 change of its input. A line with falling select set triggers on a 1-to-0 change. A line with both set triggers on either change.
- R3: An edge whose direction is not selected on that line causes no pending flag, interrupt, event or wake-up.
- R4: Writing 1 to a bit of the software trigger register acts as a rising-edge trigger on that line, even when its rising select is 0. The register always reads 0. Writing 0 triggers nothing.
- R5: A trigger sets the line's rising or falling pending bit, matching its direction, only when the line's interrupt mask bit is 1.
- R6: Writing 1 to a pending bit clears it. Writing 0 leaves it unchanged.
- R7: `line_irq[i]` is high exactly while rising or falling pending bit i is set, and stays high until software clears it.
- R8: When a line with its event mask bit at 1 triggers, `cpu_event` pulses high for one cycle. With the interrupt mask at 0 this latches no pending status.
- R9: `cpu_wake` is high while any `line_irq` bit or `cpu_event` is high.
- R10: An input edge detected in the same cycle as a write to the select register for that direction is dropped.
- R11: When a trigger and a write-1 clear hit the same pending bit in the same cycle, the bit ends up set.
- R12: `sys_wake` covers `cpu_wake`. It also rises one cycle earlier, in the cycle a trigger is detected on a line whose interrupt mask or event mask is open.
- R13: An input change made between clock edges is detected after the second rising clock edge. Its pending bit and event pulse appear after the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and detection clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| line_in | input | NLINES | Asynchronous event inputs |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | NLINES | Write data, one bit per line |
| reg_rdata | output | NLINES | Read data of the indexed register |
| line_irq | output | NLINES | Per-line interrupt |
| cpu_event | output | 1 | One-cycle event pulse |
| cpu_wake | output | 1 | Processor wake-up request |
| sys_wake | output | 1 | System wake-up request |

## Verification
The bench builds the block with NLINES set to 4. This keeps a full sweep small: every line, every combination of the two edge selects and the two masks, and both edge directions. For each case the expected pending, interrupt, event and wake values come from arithmetic on the case bits. At that size the bench can also land a select write or a pending clear in the exact detection cycle, which exercises the dropped-edge and set-wins cases.

// File: rtl/edge_event_ctrl.sv
module edge_event_ctrl #(
  parameter int NLINES = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] line_in,
  input  logic              reg_we,
  input  logic [2:0]        reg_addr,
  input  logic [NLINES-1:0] reg_wdata,
  output logic [NLINES-1:0] reg_rdata,
  output logic [NLINES-1:0] line_irq,
  output logic              cpu_event,
  output logic              cpu_wake,
  output logic              sys_wake
);
  localparam logic [2:0] A_RSEL  = 3'd0;
  localparam logic [2:0] A_FSEL  = 3'd1;
  localparam logic [2:0] A_SWT   = 3'd2;
  localparam logic [2:0] A_RPEND = 3'd3;
  localparam logic [2:0] A_FPEND = 3'd4;
  localparam logic [2:0] A_IMASK = 3'd5;
  localparam logic [2:0] A_EMASK = 3'd6;
  localparam logic [NLINES-1:0] ZERO = '0;

  logic [NLINES-1:0] sync1, sync2, last;
  logic [NLINES-1:0] rsel, fsel, rpend, fpend, imask, emask;
  logic              evt_q;

  wire wr_rsel  = reg_we && reg_addr == A_RSEL;
  wire wr_fsel  = reg_we && reg_addr == A_FSEL;
  wire wr_swt   = reg_we && reg_addr == A_SWT;
  wire wr_rpend = reg_we && reg_addr == A_RPEND;
  wire wr_fpend = reg_we && reg_addr == A_FPEND;

  wire [NLINES-1:0] rise_hit = (sync2 & ~last & rsel & {NLINES{~wr_rsel}})
                             | ({NLINES{wr_swt}} & reg_wdata);
  wire [NLINES-1:0] fall_hit = ~sync2 & last & fsel & {NLINES{~wr_fsel}};
  wire [NLINES-1:0] any_hit  = rise_hit | fall_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1 <= '0;
      sync2 <= '0;
      last  <= '0;
    end else begin
      sync1 <= line_in;
      sync2 <= sync1;
      last  <= sync2;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsel  <= '0;
      fsel  <= '0;
      imask <= '0;
      emask <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        A_RSEL:  rsel  <= reg_wdata;
        A_FSEL:  fsel  <= reg_wdata;
        A_IMASK: imask <= reg_wdata;
        A_EMASK: emask <= reg_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rpend <= '0;
      fpend <= '0;
      evt_q <= 1'b0;
    end else begin
      rpend <= (rpend & ~({NLINES{wr_rpend}} & reg_wdata)) | (rise_hit & imask);
      fpend <= (fpend & ~({NLINES{wr_fpend}} & reg_wdata)) | (fall_hit & imask);
      evt_q <= |(any_hit & emask);
    end
  end

  always_comb begin
    case (reg_addr)
      A_RSEL:  reg_rdata = rsel;
      A_FSEL:  reg_rdata = fsel;
      A_RPEND: reg_rdata = rpend;
      A_FPEND: reg_rdata = fpend;
      A_IMASK: reg_rdata = imask;
      A_EMASK: reg_rdata = emask;
      default: reg_rdata = '0;
    endcase
  end

  assign line_irq  = rpend | fpend;
  assign cpu_event = evt_q;
  assign cpu_wake  = (|line_irq) | evt_q;
  assign sys_wake  = cpu_wake | (|(any_hit & (imask | emask)));

  AST_SWT_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    reg_addr == A_SWT |-> reg_rdata == ZERO); // R4

  AST_PEND_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    (((rpend | fpend) & ~$past(rpend | fpend) & ~$past(imask)) == ZERO)); // R5

  AST_PEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(wr_rpend) |-> (($past(rpend) & ~rpend) == ZERO)); // R7

  AST_EVT_NEEDS_EMASK: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_event |-> $past(emask) != ZERO); // R8

  AST_EVT_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_event) |=> !cpu_event || $past(|(any_hit & emask))); // R8

  AST_SYS_COVERS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_wake |-> sys_wake); // R12
endmodule

// File: tb/test_edge_event_ctrl.sv
module test_edge_event_ctrl;
  localparam int N = 4;
  logic clk = 0, rst_n = 0;
  logic [N-1:0] line_in = '0;
  logic reg_we = 0;
  logic [2:0] reg_addr = '0;
  logic [N-1:0] reg_wdata = '0;
  logic [N-1:0] reg_rdata, line_irq;
  logic cpu_event, cpu_wake, sys_wake;
  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  edge_event_ctrl #(.NLINES(N)) i_edge_event_ctrl (
    .clk, .rst_n, .line_in, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .line_irq, .cpu_event, .cpu_wake, .sys_wake);

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [N-1:0] d);
    @(negedge clk); reg_we = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 0; reg_wdata = '0;
  endtask

  task automatic rd(logic [2:0] a, output logic [N-1:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic cyc(int n);
    repeat (n) @(posedge clk);
  endtask

  task automatic clear_all();
    for (int a = 0; a < 7; a++) if (a != 2) wr(3'(a), a == 3 || a == 4 ? '1 : '0);
  endtask

  initial begin
    #500000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [N-1:0] v;
    cyc(3); @(negedge clk); rst_n = 1;
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), v); chk("R1 reset reg", v, 0);
    end
    #1 chk("R1 reset outs", {line_irq, cpu_event, cpu_wake, sys_wake}, 0);

    // R2 R3 R5 R7 R8 R9 R12 R13 sweep
    for (int l = 0; l < N; l++)
      for (int cfg = 0; cfg < 16; cfg++)
        for (int dir = 0; dir < 2; dir++) begin
          logic rs, fs, im, em, hit;
          rs = cfg[0]; fs = cfg[1]; im = cfg[2]; em = cfg[3];
          hit = dir ? rs : fs;
          clear_all();
          @(negedge clk); line_in[l] = !dir[0];
          cyc(4);
          wr(0, N'(rs) << l); wr(1, N'(fs) << l);
          wr(5, N'(im) << l); wr(6, N'(em) << l);
          @(negedge clk); line_in[l] = dir[0];
          cyc(2); #1;
          chk("R13 R12 sys_wake early", sys_wake, hit & (im | em));
          chk("R13 not yet pending", line_irq, 0);
          cyc(1); #1;
          chk("R7 R5 R2 R3 line_irq", line_irq, N'(hit & im) << l);
          chk("R8 R3 cpu_event", cpu_event, hit & em);
          chk("R9 cpu_wake", cpu_wake, hit & (im | em));
          cyc(1); #1;
          chk("R8 event one cycle", cpu_event, 0);
          rd(3, v); chk("R5 R2 rise pend", v, N'(hit & im & dir[0]) << l);
          rd(4, v); chk("R5 R2 fall pend", v, N'(hit & im & !dir[0]) << l);
          cyc(3); #1;
          chk("R7 irq holds", line_irq, N'(hit & im) << l);
          wr(3, '0); wr(4, '0);
          #1 chk("R6 write 0 keeps", line_irq, N'(hit & im) << l);
          wr(dir ? 3'd3 : 3'd4, N'(1) << l);
          #1 chk("R6 R7 cleared", line_irq, 0);
          chk("R9 cpu_wake idle", cpu_wake, 0);
        end
    @(negedge clk); line_in = '0; cyc(4);
    clear_all();

    // R4 software trigger
    wr(5, '1);
    wr(2, 4'b0010);
    rd(3, v); chk("R4 swt sets rise pend", v, 4'b0010);
    rd(2, v); chk("R4 swt reads 0", v, 0);
    rd(4, v); chk("R4 no fall pend", v, 0);
    wr(3, '1);
    wr(2, '0);
    rd(3, v); chk("R4 write 0 no trigger", v, 0);
    wr(5, '0); wr(6, 4'b0100);
    @(negedge clk); reg_we = 1; reg_addr = 2; reg_wdata = 4'b0100;
    @(negedge clk); reg_we = 0;
    chk("R8 swt event pulse", cpu_event, 1);
    rd(3, v); chk("R8 no pending when masked", v, 0);
    clear_all();

    // R10 edge during select write dropped
    wr(0, 4'b0001); wr(5, 4'b0001);
    @(negedge clk); line_in[0] = 1;
    cyc(2);
    @(negedge clk); reg_we = 1; reg_addr = 0; reg_wdata = 4'b0001;
    @(negedge clk); reg_we = 0;
    rd(3, v); chk("R10 edge dropped", v, 0);
    @(negedge clk); line_in[0] = 0; cyc(4);

    // R11 set beats clear
    wr(2, 4'b0001);
    rd(3, v); chk("R11 precondition", v, 4'b0001);
    @(negedge clk); line_in[0] = 1;
    cyc(2);
    @(negedge clk); reg_we = 1; reg_addr = 3; reg_wdata = 4'b0001;
    @(negedge clk); reg_we = 0;
    rd(3, v); chk("R11 set wins", v, 4'b0001);
    wr(3, '1);
    rd(3, v); chk("R6 cleared after", v, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule